// File: doc/BRIEF.md
# Inter-Processor Mailbox with Interrupts

This peripheral lets several processors pass 32-bit words to each other through a bank of small hardware queues. A sender writes a word to a mailbox's message location, and the receiver reads the same location to take the oldest queued word. Each queue also has a location that reports whether it is full and a location that reports how many words it holds.

Every user (processor) has its own interrupt status register, interrupt enable register and interrupt line. Each mailbox m owns two event bits in those registers. Bit 2m records that a word arrived. Bit 2m+1 records that a full queue gained a free slot. A user writes 1s to its status register to clear bits, and its line is raised for any bit that is set in both status and enable.

A parameter selects one of two register layouts for the per-user registers. The newer layout adds an enable-clear register next to the status and enable registers. The register port has no back-pressure: every read or write is accepted in the cycle it is presented. Read data appears one cycle after the read strobe and holds until the next read.

Top module: `ipc_mailbox`

## Requirements
- R1: A read of offset 0x000 returns the revision, with the major number in bits [7:4] and the minor number in bits [3:0] (default 0x21). All other bits are zero.
- R2: A write to offset 0x040+4m appends the word to mailbox m's queue. A read of that offset removes the oldest word and returns it on rdata in the cycle after the read strobe, so words come out in the order they were written.
- R3: A read of offset 0x080+4m returns 1 when mailbox m holds DEPTH words and 0 otherwise.
- R4: A read of offset 0x0C0+4m returns the number of words queued in mailbox m, where 0 means empty.
- R5: A write to a full mailbox is discarded and sets bit m of drop_o, which then stays set until reset. A read from an empty mailbox returns 0 and leaves the queue unchanged.
- R6: Each accepted write to mailbox m sets status bit 2m for every user. Each read that takes mailbox m from full to not full sets status bit 2m+1 for every user.
- R7: Writing 1s to a user's status register clears those bits and leaves the other bits unchanged. If a set event and a clear hit the same bit in the same cycle, the bit stays set.
- R8: irq_o[u] is a registered output. It is high in the cycle after user u has at least one bit set in both status and enable, and it is low while reset is asserted.
- R9: With NEW_LAYOUT=0, user u's status register is at 0x100+8u and its enable register is at 0x104+8u. A write to the enable register replaces its whole value.
- R10: With NEW_LAYOUT=1, user u's status register is at 0x104+0x10u and its enable register is at 0x108+0x10u. A write to the enable register ORs the written 1s into it. A write of 1s to 0x10C+0x10u clears the matching enable bits, and a read of that offset returns the enable value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| addr | input | AW | Byte offset of the access |
| wr_en | input | 1 | Write strobe |
| wdata | input | DW | Write data |
| rd_en | input | 1 | Read strobe |
| rdata | output | DW | Read data, valid the cycle after rd_en |
| irq_o | output | N_USER | One interrupt line per user |
| drop_o | output | N_BOX | Sticky flag per mailbox: a write was discarded because the queue was full |

## Verification
The hardest event to reach is the not-full event. It only fires when a read drains a mailbox that is exactly full, so the stimulus first writes DEPTH words to one mailbox and then sends one more write to exercise the discard path. Only after that does it pop one word, and it checks the new bit in another user's status register. The second layout is exercised on a separate instance. On that instance, a set-style enable write followed by an enable-clear write has to show up both in the enable readback and in the interrupt line falling.

// File: rtl/mbx_pkg.sv
package mbx_pkg;
  localparam int REV_OFS  = 'h000;
  localparam int MSG_BASE = 'h040;
  localparam int FUL_BASE = 'h080;
  localparam int CNT_BASE = 'h0C0;

  function automatic int st_ofs(input bit nl, input int u);
    return nl ? ('h104 + 'h10 * u) : ('h100 + 8 * u);
  endfunction

  function automatic int en_ofs(input bit nl, input int u);
    return nl ? ('h108 + 'h10 * u) : ('h104 + 8 * u);
  endfunction

  function automatic int clr_ofs(input int u);
    return 'h10C + 'h10 * u;
  endfunction
endpackage

// File: rtl/mbx_fifo.sv
module mbx_fifo #(
  parameter int DW    = 32,
  parameter int DEPTH = 4
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         push,
  input  logic                         pop,
  input  logic [DW-1:0]                din,
  output logic [DW-1:0]                head,
  output logic                         full,
  output logic                         empty,
  output logic [$clog2(DEPTH+1)-1:0]   count
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [DW-1:0] mem [DEPTH];
  logic [PW-1:0] wp, rp;
  logic [CW-1:0] cnt;

  function automatic logic [PW-1:0] adv(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (push) mem[wp] <= din;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp  <= '0;
      rp  <= '0;
      cnt <= '0;
    end else begin
      if (push) wp <= adv(wp);
      if (pop)  rp <= adv(rp);
      case ({push, pop})
        2'b10:   cnt <= cnt + 1'b1;
        2'b01:   cnt <= cnt - 1'b1;
        default: cnt <= cnt;
      endcase
    end
  end

  assign head  = mem[rp];
  assign full  = (cnt == CW'(DEPTH));
  assign empty = (cnt == '0);
  assign count = cnt;
endmodule

// File: rtl/mbx_user_irq.sv
module mbx_user_irq #(
  parameter int NB         = 8,
  parameter bit NEW_LAYOUT = 1'b0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [NB-1:0] set_vec,
  input  logic          w1c,
  input  logic          en_wr,
  input  logic          en_clr,
  input  logic [NB-1:0] wmask,
  output logic [NB-1:0] st,
  output logic [NB-1:0] en,
  output logic          irq
);
  logic [NB-1:0] en_nxt;

  generate
    if (NEW_LAYOUT) begin : g_setclr
      always_comb begin
        en_nxt = en;
        if (en_wr)  en_nxt = en_nxt | wmask;
        if (en_clr) en_nxt = en_nxt & ~wmask;
      end
    end else begin : g_direct
      assign en_nxt = en_wr ? wmask : en;
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st  <= '0;
      en  <= '0;
      irq <= 1'b0;
    end else begin
      st  <= (st & ~(w1c ? wmask : '0)) | set_vec;
      en  <= en_nxt;
      irq <= |(st & en);
    end
  end
endmodule

// File: rtl/ipc_mailbox.sv
module ipc_mailbox
  import mbx_pkg::*;
#(
  parameter int         DW         = 32,
  parameter int         AW         = 10,
  parameter int         N_BOX      = 4,
  parameter int         N_USER     = 4,
  parameter int         DEPTH      = 4,
  parameter bit         NEW_LAYOUT = 1'b0,
  parameter logic [3:0] REV_MAJOR  = 4'h2,
  parameter logic [3:0] REV_MINOR  = 4'h1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [AW-1:0]     addr,
  input  logic              wr_en,
  input  logic [DW-1:0]     wdata,
  input  logic              rd_en,
  output logic [DW-1:0]     rdata,
  output logic [N_USER-1:0] irq_o,
  output logic [N_BOX-1:0]  drop_o
);
  localparam int NB2 = 2 * N_BOX;
  localparam int CW  = $clog2(DEPTH + 1);

  logic [N_BOX-1:0]        hit_msg, push_v, pop_v, full_v, empty_v, drop_q;
  logic [N_BOX*CW-1:0]     cnt_flat;
  logic [N_BOX*DW-1:0]     head_flat;
  logic [NB2-1:0]          set_vec;
  logic [N_USER*NB2-1:0]   st_flat, en_flat;
  logic [DW-1:0]           rd_nxt;

  genvar m, u;
  generate
    for (m = 0; m < N_BOX; m++) begin : g_box
      assign hit_msg[m]      = (addr == AW'(MSG_BASE + 4 * m));
      assign push_v[m]       = wr_en && hit_msg[m] && !full_v[m];
      assign pop_v[m]        = rd_en && hit_msg[m] && !empty_v[m];
      assign set_vec[2*m]    = push_v[m];
      assign set_vec[2*m+1]  = pop_v[m] && full_v[m];

      mbx_fifo #(.DW(DW), .DEPTH(DEPTH)) u_q (
        .clk   (clk),
        .rst_n (rst_n),
        .push  (push_v[m]),
        .pop   (pop_v[m]),
        .din   (wdata),
        .head  (head_flat[m*DW +: DW]),
        .full  (full_v[m]),
        .empty (empty_v[m]),
        .count (cnt_flat[m*CW +: CW])
      );
    end

    for (u = 0; u < N_USER; u++) begin : g_usr
      logic st_hit, en_hit, clr_hit;
      assign st_hit  = wr_en && (addr == AW'(st_ofs(NEW_LAYOUT, u)));
      assign en_hit  = wr_en && (addr == AW'(en_ofs(NEW_LAYOUT, u)));
      assign clr_hit = NEW_LAYOUT && wr_en && (addr == AW'(clr_ofs(u)));

      mbx_user_irq #(.NB(NB2), .NEW_LAYOUT(NEW_LAYOUT)) u_ui (
        .clk     (clk),
        .rst_n   (rst_n),
        .set_vec (set_vec),
        .w1c     (st_hit),
        .en_wr   (en_hit),
        .en_clr  (clr_hit),
        .wmask   (wdata[NB2-1:0]),
        .st      (st_flat[u*NB2 +: NB2]),
        .en      (en_flat[u*NB2 +: NB2]),
        .irq     (irq_o[u])
      );
    end
  endgenerate

  // sticky discard flags
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) drop_q <= '0;
    else        drop_q <= drop_q | (hit_msg & full_v & {N_BOX{wr_en}});
  end
  assign drop_o = drop_q;

  // read selection
  always_comb begin
    rd_nxt = '0;
    if (addr == AW'(REV_OFS)) rd_nxt = DW'({REV_MAJOR, REV_MINOR});
    for (int i = 0; i < N_BOX; i++) begin
      if (hit_msg[i])
        rd_nxt = empty_v[i] ? '0 : head_flat[i*DW +: DW];
      if (addr == AW'(FUL_BASE + 4 * i)) rd_nxt = DW'(full_v[i]);
      if (addr == AW'(CNT_BASE + 4 * i)) rd_nxt = DW'(cnt_flat[i*CW +: CW]);
    end
    for (int j = 0; j < N_USER; j++) begin
      if (addr == AW'(st_ofs(NEW_LAYOUT, j))) rd_nxt = DW'(st_flat[j*NB2 +: NB2]);
      if (addr == AW'(en_ofs(NEW_LAYOUT, j))) rd_nxt = DW'(en_flat[j*NB2 +: NB2]);
      if (NEW_LAYOUT && addr == AW'(clr_ofs(j))) rd_nxt = DW'(en_flat[j*NB2 +: NB2]);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     rdata <= '0;
    else if (rd_en) rdata <= rd_nxt;
  end
endmodule

// File: rtl/mbx_checker.sv
module mbx_checker
  import mbx_pkg::*;
#(
  parameter int         DW        = 32,
  parameter int         AW        = 10,
  parameter int         N_BOX     = 4,
  parameter int         N_USER    = 4,
  parameter int         DEPTH     = 4,
  parameter logic [3:0] REV_MAJOR = 4'h2,
  parameter logic [3:0] REV_MINOR = 4'h1,
  localparam int        NB2       = 2 * N_BOX,
  localparam int        CW        = $clog2(DEPTH + 1)
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic [AW-1:0]         addr,
  input logic                  wr_en,
  input logic                  rd_en,
  input logic [DW-1:0]         rdata,
  input logic [N_USER-1:0]     irq_o,
  input logic [N_BOX-1:0]      drop_o,
  input logic [N_BOX*CW-1:0]   cnt_flat,
  input logic [N_USER*NB2-1:0] st_flat,
  input logic [N_USER*NB2-1:0] en_flat,
  input logic [N_BOX-1:0]      push_v,
  input logic [N_BOX-1:0]      pop_v,
  input logic [N_BOX-1:0]      full_v,
  input logic [N_BOX-1:0]      empty_v
);
  assert_rev_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && addr == AW'(REV_OFS)) |=> (rdata == DW'({REV_MAJOR, REV_MINOR})));

  genvar m, u;
  generate
    for (m = 0; m < N_BOX; m++) begin : g_b
      assert_no_overflow_R4: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_flat[m*CW +: CW] <= CW'(DEPTH));
      assert_drop_sticky_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !$fell(drop_o[m]));
      assert_drop_keeps_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !rd_en && addr == AW'(MSG_BASE + 4 * m) && full_v[m])
          |=> ($stable(cnt_flat[m*CW +: CW]) && drop_o[m]));
      assert_empty_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && addr == AW'(MSG_BASE + 4 * m) && empty_v[m]) |=> (rdata == '0));
      for (u = 0; u < N_USER; u++) begin : g_u
        assert_newmsg_R6: assert property (@(posedge clk) disable iff (!rst_n)
          push_v[m] |=> st_flat[u*NB2 + 2*m]);
        assert_notfull_R6: assert property (@(posedge clk) disable iff (!rst_n)
          (pop_v[m] && full_v[m]) |=> st_flat[u*NB2 + 2*m + 1]);
      end
    end
    for (u = 0; u < N_USER; u++) begin : g_i
      assert_irq_enabled_R8: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o[u] |-> $past(|en_flat[u*NB2 +: NB2]));
    end
  endgenerate
endmodule

bind ipc_mailbox mbx_checker #(
  .DW(DW), .AW(AW), .N_BOX(N_BOX), .N_USER(N_USER), .DEPTH(DEPTH),
  .REV_MAJOR(REV_MAJOR), .REV_MINOR(REV_MINOR)
) u_chk (
  .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .rd_en(rd_en),
  .rdata(rdata), .irq_o(irq_o), .drop_o(drop_o), .cnt_flat(cnt_flat),
  .st_flat(st_flat), .en_flat(en_flat), .push_v(push_v), .pop_v(pop_v),
  .full_v(full_v), .empty_v(empty_v)
);

// File: tb/sim_ipc_mailbox.sv
`timescale 1ns/1ps
module sim_ipc_mailbox;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  logic [9:0]  a_addr = '0, b_addr = '0;
  logic        a_wr = 0, a_rd = 0, b_wr = 0, b_rd = 0;
  logic [31:0] a_wd = '0, b_wd = '0;
  logic [31:0] a_rdata, b_rdata;
  logic [3:0]  a_irq, b_irq, a_drop, b_drop;

  ipc_mailbox #(.NEW_LAYOUT(1'b0)) u0 (
    .clk(clk), .rst_n(rst_n), .addr(a_addr), .wr_en(a_wr), .wdata(a_wd),
    .rd_en(a_rd), .rdata(a_rdata), .irq_o(a_irq), .drop_o(a_drop));

  ipc_mailbox #(.NEW_LAYOUT(1'b1)) u1 (
    .clk(clk), .rst_n(rst_n), .addr(b_addr), .wr_en(b_wr), .wdata(b_wd),
    .rd_en(b_rd), .rdata(b_rdata), .irq_o(b_irq), .drop_o(b_drop));

  int checks = 0;
  int errors = 0;

  logic [31:0] exp_a[$], exp_b[$];
  string       tag_a[$], tag_b[$];
  logic        seen_a = 0, seen_b = 0;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // driver tasks
  task automatic wr(input int which, input logic [9:0] ad, input logic [31:0] d);
    @(negedge clk);
    if (which == 0) begin a_addr = ad; a_wd = d; a_wr = 1; end
    else            begin b_addr = ad; b_wd = d; b_wr = 1; end
    @(negedge clk);
    a_wr = 0; b_wr = 0;
  endtask

  task automatic rd(input int which, input logic [9:0] ad, input logic [31:0] e, input string tag);
    @(negedge clk);
    if (which == 0) begin a_addr = ad; a_rd = 1; exp_a.push_back(e); tag_a.push_back(tag); end
    else            begin b_addr = ad; b_rd = 1; exp_b.push_back(e); tag_b.push_back(tag); end
    @(negedge clk);
    a_rd = 0; b_rd = 0;
  endtask

  // monitor: compares read data the cycle after each accepted read
  always @(posedge clk) begin
    seen_a <= a_rd;
    seen_b <= b_rd;
  end

  always @(negedge clk) begin
    if (seen_a && exp_a.size() > 0) chk(tag_a.pop_front(), a_rdata, exp_a.pop_front());
    if (seen_b && exp_b.size() > 0) chk(tag_b.pop_front(), b_rdata, exp_b.pop_front());
  end

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R8 irq in reset", {28'd0, a_irq}, 32'h0);
    rst_n = 1;
    chk("R5 drop after reset", {28'd0, a_drop}, 32'h0);

    rd(0, 10'h000, 32'h21, "R1 revision");
    rd(0, 10'h0C0, 32'h0, "R4 empty count");
    rd(0, 10'h040, 32'h0, "R5 pop empty");
    rd(0, 10'h0C0, 32'h0, "R5 count unchanged");

    wr(0, 10'h040, 32'hAAAA0001);
    wr(0, 10'h040, 32'hBBBB0002);
    rd(0, 10'h0C0, 32'h2, "R4 count two");
    rd(0, 10'h080, 32'h0, "R3 not full");
    rd(0, 10'h100, 32'h1, "R6 user0 newmsg");
    rd(0, 10'h110, 32'h1, "R6 user2 newmsg");
    chk("R8 irq off without enable", {28'd0, a_irq}, 32'h0);

    wr(0, 10'h104, 32'h1);
    @(negedge clk);
    chk("R9 irq0 after enable", {31'd0, a_irq[0]}, 32'h1);
    chk("R8 irq1 stays low", {31'd0, a_irq[1]}, 32'h0);
    rd(0, 10'h104, 32'h1, "R9 enable readback");

    wr(0, 10'h100, 32'h1);
    @(negedge clk);
    chk("R7 irq0 after clear", {31'd0, a_irq[0]}, 32'h0);
    rd(0, 10'h100, 32'h0, "R7 status cleared");

    wr(0, 10'h040, 32'hCCCC0003);
    wr(0, 10'h040, 32'hDDDD0004);
    rd(0, 10'h080, 32'h1, "R3 full");
    rd(0, 10'h0C0, 32'h4, "R4 count four");
    wr(0, 10'h040, 32'hEEEE0005);
    chk("R5 drop flag", {28'd0, a_drop}, 32'h1);
    rd(0, 10'h0C0, 32'h4, "R5 count after drop");

    rd(0, 10'h040, 32'hAAAA0001, "R2 pop first");
    rd(0, 10'h108, 32'h3, "R6 user1 notfull");
    rd(0, 10'h080, 32'h0, "R3 no longer full");
    rd(0, 10'h040, 32'hBBBB0002, "R2 pop second");
    rd(0, 10'h040, 32'hCCCC0003, "R2 pop third");
    rd(0, 10'h040, 32'hDDDD0004, "R2 pop fourth");
    rd(0, 10'h040, 32'h0, "R5 pop empty again");
    chk("R5 drop sticky", {28'd0, a_drop}, 32'h1);

    wr(0, 10'h04C, 32'h12345678);
    rd(0, 10'h118, 32'h43, "R6 user3 box3 bit");
    rd(0, 10'h0CC, 32'h1, "R4 box3 count");
    wr(0, 10'h118, 32'h40);
    rd(0, 10'h118, 32'h03, "R7 partial clear");

    // newer layout instance
    wr(1, 10'h048, 32'h55);
    rd(1, 10'h114, 32'h10, "R10 user1 status");
    wr(1, 10'h118, 32'h10);
    @(negedge clk);
    chk("R10 irq1 on", {31'd0, b_irq[1]}, 32'h1);
    wr(1, 10'h118, 32'h01);
    rd(1, 10'h118, 32'h11, "R10 enable set merge");
    wr(1, 10'h11C, 32'h10);
    rd(1, 10'h118, 32'h01, "R10 enable after clear");
    rd(1, 10'h11C, 32'h01, "R10 clear reg readback");
    chk("R10 irq1 off", {31'd0, b_irq[1]}, 32'h0);
    wr(1, 10'h114, 32'h10);
    rd(1, 10'h114, 32'h0, "R10 status w1c");
    rd(1, 10'h048, 32'h55, "R2 newer layout pop");

    repeat (3) @(negedge clk);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule